// File: doc/BRIEF.md
# Legacy Peripheral Configuration Port (Index/Data Pair)

This block gives a host access to a table of 256 byte-wide configuration entries that describe legacy peripherals: a floppy controller, a parallel port and two serial ports. Two neighbouring I/O addresses form the access window. A byte written to the lower address (`BASE`, default 0x3F0) becomes the current index. The upper address (`BASE+1`, default 0x3F1) then reads or writes the table entry that the index selects.

The window responds only while `cfg_en` is high. A bridge configuration control bit drives this input, and that bit is clear after reset. While the window is closed, reads return 0xFF and writes have no effect. Only single-byte accesses are accepted. The device-identification entry cannot be written. Read data is registered and comes back with a one-cycle valid pulse.

Top module: `sio_cfg_port`

## Requirements
- R1: A byte write (`io_size` = 0) to `BASE` while `cfg_en` is high loads `io_wdata` into the index. A read of `BASE` returns the current index.
- R2: A byte write to `BASE+1` while `cfg_en` is high stores `io_wdata` into the entry the index selects. A later read of `BASE+1` returns that entry.
- R3: A read strobe to `BASE` or `BASE+1` raises `rd_valid` for exactly one cycle, on the clock edge after the strobe, with `rd_data` valid in that cycle. Reads are byte wide only.
- R4: After reset the table holds 0x3C at index 0xE0 (device ID), 0x03 at 0xE2 (function select), 0xFC at 0xE3 (floppy base), 0xDE at 0xE6 (parallel base), 0xFE at 0xE7 (first serial base) and 0xBE at 0xE8 (second serial base).
- R5: After reset the index is 0x00, and every entry not listed in R4 is 0x00.
- R6: Entry 0xE0 is read-only. A data write to it leaves it unchanged. The index can still be written afterwards and selects other entries normally.
- R7: While `cfg_en` is low, reads of either port address return 0xFF and writes change neither the index nor any entry.
- R8: An access with `io_size` not equal to 0 (1 = 16-bit, 2 = 32-bit, 3 = reserved) changes no state. A read of this kind returns 0xFF.
- R9: Accesses to any address other than `BASE` and `BASE+1` change no state and never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Window enable from the bridge configuration bit |
| io_addr | input | 16 | I/O address of the access |
| io_size | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The bench writes to the locked device-ID entry and then reads it back. A design with broken protection would return the written byte instead of 0x3C. It also checks that the index still moves after such a write. Writes issued while the window is closed, writes with a wide access size and writes to neighbouring addresses are each followed by index and data reads. A design that leaks any of these would show a changed index or entry. Every reset default and several zero entries are read back, so a wrong constant or a missing reset would show up. A random mix of index moves, data writes, enable changes and odd widths is compared against a bench model of the table. The bench also checks that the valid pulse lasts exactly one cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = 8;
    localparam int ENTRIES = 1 << IDX_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // access width encoding on io_size
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    // value returned by a read that the window refuses
    localparam byte_t FLOAT_READ = 8'hFF;

    // table slots with a defined power-up value
    localparam idx_t SLOT_DEVID  = 8'hE0;
    localparam idx_t SLOT_FUNSEL = 8'hE2;
    localparam idx_t SLOT_FDC    = 8'hE3;
    localparam idx_t SLOT_LPT    = 8'hE6;
    localparam idx_t SLOT_COM1   = 8'hE7;
    localparam idx_t SLOT_COM2   = 8'hE8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_DAT_WR,
        ACC_IDX_RD,
        ACC_DAT_RD,
        ACC_FLOAT_RD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        byte_t     data;
    } acc_t;

    function automatic byte_t slot_reset_value(idx_t slot);
        byte_t v;
        unique case (slot)
            SLOT_DEVID:  v = 8'h3C;
            SLOT_FUNSEL: v = 8'h03;
            SLOT_FDC:    v = 8'hFC;
            SLOT_LPT:    v = 8'hDE;
            SLOT_COM1:   v = 8'hFE;
            SLOT_COM2:   v = 8'hBE;
            default:     v = '0;
        endcase
        return v;
    endfunction

    function automatic logic acc_is_read(acc_kind_e k);
        return (k == ACC_IDX_RD) || (k == ACC_DAT_RD) || (k == ACC_FLOAT_RD);
    endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h03F0
) (
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_wr,
    input  logic              io_rd,
    input  byte_t             io_wdata,
    output acc_t              acc
);

    localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE) + ADDR_W'(1);

    logic hit_idx, hit_dat, open_ok;

    assign hit_idx = (io_addr == IDX_ADDR);
    assign hit_dat = (io_addr == DAT_ADDR);
    assign open_ok = cfg_en && (io_size == SZ_BYTE);

    always_comb begin
        acc.kind = ACC_NONE;
        acc.data = io_wdata;
        if (io_wr) begin
            if (open_ok && hit_idx)      acc.kind = ACC_IDX_WR;
            else if (open_ok && hit_dat) acc.kind = ACC_DAT_WR;
        end else if (io_rd && (hit_idx || hit_dat)) begin
            if (!open_ok)     acc.kind = ACC_FLOAT_RD;
            else if (hit_idx) acc.kind = ACC_IDX_RD;
            else              acc.kind = ACC_DAT_RD;
        end
    end

endmodule

// File: rtl/sio_cfg_index.sv
module sio_cfg_index
    import sio_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  byte_t load_val,
    output idx_t idx_q
);

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (load) idx_q <= idx_t'(load_val);
    end

endmodule

// File: rtl/sio_cfg_table.sv
module sio_cfg_table
    import sio_cfg_pkg::*;
#(
    parameter logic [ENTRIES-1:0] LOCK_MASK = ENTRIES'(1) << SLOT_DEVID
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  waddr,
    input  byte_t wdata,
    input  idx_t  raddr,
    output byte_t rdata
);

    byte_t mem [ENTRIES];
    logic  wr_allowed;

    assign wr_allowed = we && !LOCK_MASK[waddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= slot_reset_value(idx_t'(i));
        end else if (wr_allowed) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R2: an accepted write lands in the addressed slot
    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !LOCK_MASK[waddr]) |=> mem[$past(waddr)] == $past(wdata));

    // R6: a protected slot keeps its value across a write attempt
    assert_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (we && LOCK_MASK[waddr]) |=> mem[$past(waddr)] == $past(mem[waddr]));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    acc_t  acc;
    idx_t  idx_q;
    byte_t tbl_rdata;
    byte_t rd_next;

    sio_cfg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .cfg_en   (cfg_en),
        .io_addr  (io_addr),
        .io_size  (io_size),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .acc      (acc)
    );

    sio_cfg_index u_index (
        .clk      (clk),
        .rst      (rst),
        .load     (acc.kind == ACC_IDX_WR),
        .load_val (acc.data),
        .idx_q    (idx_q)
    );

    sio_cfg_table u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.kind == ACC_DAT_WR),
        .waddr (idx_q),
        .wdata (acc.data),
        .raddr (idx_q),
        .rdata (tbl_rdata)
    );

    always_comb begin
        unique case (acc.kind)
            ACC_IDX_RD: rd_next = byte_t'(idx_q);
            ACC_DAT_RD: rd_next = tbl_rdata;
            default:    rd_next = FLOAT_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_is_read(acc.kind);
            if (acc_is_read(acc.kind)) rd_data <= rd_next;
        end
    end

    // R3: a read strobe on the pair yields a valid pulse on the next edge
    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && (io_addr == ADDR_W'(BASE) || io_addr == ADDR_W'(BASE) + ADDR_W'(1)))
        |=> rd_valid);

    // R9: no valid pulse without a strobe on the pair
    assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && (io_addr == ADDR_W'(BASE) || io_addr == ADDR_W'(BASE) + ADDR_W'(1)))
        |=> !rd_valid);

    // R7: a closed window returns the float value and holds the index
    assert_closed_read_R7: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && !cfg_en && (io_addr == ADDR_W'(BASE) + ADDR_W'(1)))
        |=> rd_data == 8'hFF);

    assert_closed_index_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(idx_q));

    // R8: a wide read is refused
    assert_wide_read_R8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && io_size != 2'd0 && (io_addr == ADDR_W'(BASE)))
        |=> rd_data == 8'hFF);

endmodule

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_IDX = 16'h03F0;
    localparam logic [15:0] P_DAT = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_en;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic        io_wr, io_rd;
    logic [7:0]  io_wdata;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] m_tbl [256];
    logic [7:0] m_idx;
    logic       m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .io_addr(io_addr), .io_size(io_size),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_default(int i);
        case (i)
            8'hE8: return 8'hBE;
            8'hE7: return 8'hFE;
            8'hE6: return 8'hDE;
            8'hE3: return 8'hFC;
            8'hE2: return 8'h03;
            8'hE0: return 8'h3C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic pair_hit(logic [15:0] a);
        return (a == P_IDX) || (a == P_DAT);
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a, logic [1:0] sz);
        if (!m_en || sz != 2'd0) return 8'hFF;
        if (a == P_IDX) return m_idx;
        return m_tbl[m_idx];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        cfg_en = v;
        m_en = v;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz);
        @(negedge clk);
        io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (m_en && sz == 2'd0) begin
            if (a == P_IDX) m_idx = d;
            else if (a == P_DAT && m_idx != 8'hE0) m_tbl[m_idx] = d;
        end
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] sz, input string req);
        logic [7:0] e;
        logic       h;
        e = exp_read(a, sz);
        h = pair_hit(a);
        @(negedge clk);
        io_addr = a; io_size = sz; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        if (h) begin
            chk(rd_valid === 1'b1, {req, "/R3 valid"}, int'(rd_valid), 1);
            chk(rd_data === e, req, int'(rd_data), int'(e));
        end else begin
            chk(rd_valid === 1'b0, {req, "/R9 no valid"}, int'(rd_valid), 0);
        end
        @(negedge clk);
        chk(rd_valid === 1'b0, "R3 single pulse", int'(rd_valid), 0);
    endtask

    task automatic read_slot(input logic [7:0] s, input string req);
        do_write(P_IDX, s, 2'd0);
        do_read(P_DAT, 2'd0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [1:0]  sz;
        int          op;
        void'($urandom(32'h5EED_0C0F));
        for (int i = 0; i < 256; i++) m_tbl[i] = exp_default(i);
        m_idx = 8'h00; m_en = 1'b0;
        rst = 1'b1; cfg_en = 1'b0; io_addr = '0; io_size = '0;
        io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk(rd_valid === 1'b0, "R3 reset valid", int'(rd_valid), 0);
        do_read(P_DAT, 2'd0, "R7 closed after reset");
        set_en(1'b1);
        do_read(P_IDX, 2'd0, "R5 index reset");
        do_read(P_DAT, 2'd0, "R5 slot 0 reset");

        // R4 defaults
        read_slot(8'hE0, "R4 devid");
        read_slot(8'hE2, "R4 funsel");
        read_slot(8'hE3, "R4 fdc");
        read_slot(8'hE6, "R4 lpt");
        read_slot(8'hE7, "R4 com1");
        read_slot(8'hE8, "R4 com2");
        read_slot(8'hE1, "R5 zero slot");
        read_slot(8'hFF, "R5 zero slot top");

        // R1 / R2
        do_write(P_IDX, 8'h5A, 2'd0);
        do_read(P_IDX, 2'd0, "R1 index readback");
        do_write(P_DAT, 8'hA7, 2'd0);
        do_read(P_DAT, 2'd0, "R2 store");

        // R6 protected slot, then index still moves
        do_write(P_IDX, 8'hE0, 2'd0);
        do_write(P_DAT, 8'h55, 2'd0);
        do_read(P_DAT, 2'd0, "R6 devid unchanged");
        do_write(P_IDX, 8'hE2, 2'd0);
        do_read(P_IDX, 2'd0, "R6 index moves");
        do_write(P_DAT, 8'h0F, 2'd0);
        do_read(P_DAT, 2'd0, "R6 neighbour writable");

        // R7 closed window ignores writes
        set_en(1'b0);
        do_write(P_IDX, 8'h10, 2'd0);
        do_write(P_DAT, 8'h99, 2'd0);
        do_read(P_IDX, 2'd0, "R7 closed index read");
        set_en(1'b1);
        do_read(P_IDX, 2'd0, "R7 index held");
        do_read(P_DAT, 2'd0, "R7 slot held");

        // R8 wide accesses
        do_write(P_IDX, 8'h33, 2'd1);
        do_write(P_DAT, 8'h44, 2'd2);
        do_read(P_DAT, 2'd2, "R8 wide read");
        do_read(P_IDX, 2'd0, "R8 index held");
        do_read(P_DAT, 2'd0, "R8 slot held");

        // R9 foreign addresses
        do_write(16'h03F2, 8'h21, 2'd0);
        do_write(16'h03EF, 8'h22, 2'd0);
        do_read(16'h03F2, 2'd0, "R9 foreign read");
        do_read(P_IDX, 2'd0, "R9 index held");
        do_read(P_DAT, 2'd0, "R9 slot held");

        // random mix against the model
        for (int n = 0; n < 700; n++) begin
            op = $urandom % 10;
            sz = (($urandom % 8) == 0) ? 2'(1 + ($urandom % 3)) : 2'd0;
            case ($urandom % 10)
                0:       a = 16'h03F2;
                1:       a = 16'h03EF;
                2, 3, 4: a = P_IDX;
                default: a = P_DAT;
            endcase
            case (op)
                0, 1, 2: do_write(P_IDX,
                         (($urandom % 2) == 0) ? 8'(8'hE0 + ($urandom % 10)) : 8'($urandom), sz);
                3, 4:    do_write(a, 8'($urandom), sz);
                5, 6, 7: do_read(a, sz, "R2 random read");
                8:       do_read(P_IDX, sz, "R1 random index read");
                default: set_en(($urandom % 4) != 0);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule